// File: doc/BRIEF.md
# Edge-Latched Interrupt Status Controller

This block gathers six single-bit event sources, all synchronous to the system clock, into one sticky status register and drives a single interrupt request line. Each source has its own enable bit. While a source is enabled, a low-to-high transition on it latches a status bit that stays set. The block has no separate acknowledge register. Software clears a latched bit by writing its enable bit to zero, and can then write it back to one to arm the source again.

The interrupt request rises when the status register changes from all zeros to any nonzero value. It stays high until every status bit has been cleared. Software therefore services an interrupt by reading the status register and then disabling and re-enabling the sources it has handled. The register port is a single-cycle write strobe with an address and data, and the read data is combinational.

Top module: `isc_intr_ctrl`

## Requirements
- R1: After reset, the enable register and the status register are zero, `irq_out` is low and `reg_rdata` reads zero.
- R2: When source i is enabled and `src_in[i]` goes from 0 in one clock to 1 in the next, status bit i is 1 from the clock edge that samples the 1.
- R3: A rising edge on a source whose enable bit is 0 leaves its status bit at 0.
- R4: A status bit that is set stays set while its source falls and rises again, for as long as its enable bit stays 1.
- R5: A write with `reg_we`=1 and `reg_addr`=0 loads `reg_wdata[5:0]` into the enable register, where bit i enables source i. Every source written with 0 has its status bit cleared at that same edge, and the other status bits keep their values.
- R6: A write to `reg_addr`=1 changes neither the status bits nor the enable bits. No other way exists to clear a status bit.
- R7: A source that is already high when its enable bit is set does not set its status bit. A later rising edge does set it.
- R8: When a write clears the enable bit of a source at the same edge that samples a rising edge on that source, the status bit ends at 0.
- R9: `irq_out` rises at the same edge at which the status register goes from all zeros to nonzero.
- R10: `irq_out` stays high while any status bit is set and falls at the edge at which the last status bit is cleared.
- R11: `reg_rdata` returns the six status bits in bits 5:0 and zero in bits 7:6, at either address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 1 | Register select: 0 is the enable register, 1 is the status register (writes to it are ignored) |
| reg_wdata | input | 8 | Write data; bits 5:0 are the per-source enables |
| reg_rdata | output | 8 | Status register, zero-extended |
| src_in | input | 6 | Interrupt source signals, synchronous to clk |
| status_out | output | 6 | Latched status bits |
| irq_out | output | 1 | Interrupt request |

## Verification
A status bit that latches wrongly, or fails to clear, shows up on `status_out` and `reg_rdata` one edge after the stimulus. An interrupt flag that falls out of step with the status register shows on `irq_out` at that same edge. A stale copy of a source in the edge detector shows up one cycle after an enable write, as a bit set by a level that was already high. The bench samples every result one edge after each write or source change, so any of these faults is reported at the first edge where it appears.

// File: rtl/isc_pkg.sv
package isc_pkg;
   // Number of event sources and width of the register port data.
   localparam int unsigned ISC_NUM_SRC = 6;
   localparam int unsigned ISC_DATA_W  = 8;
   localparam int unsigned ISC_ADDR_W  = 1;

   // Register select values on the port.
   typedef enum logic [ISC_ADDR_W-1:0] {
      ISC_SEL_ENABLE = 1'b0,
      ISC_SEL_STATUS = 1'b1
   } isc_sel_e;
endpackage

// File: rtl/isc_edge_det.sv
module isc_edge_det #(
   parameter int unsigned WIDTH = isc_pkg::ISC_NUM_SRC
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] sig_in,
   output logic [WIDTH-1:0] sig_prev,
   output logic [WIDTH-1:0] rise
);
   initial begin
      if (WIDTH < 1) $error("isc_edge_det: WIDTH must be at least 1");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_lane
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= sig_in[i];
      end
      assign sig_prev[i] = prev_q;
      assign rise[i]     = sig_in[i] & ~prev_q;
   end
endmodule

// File: rtl/isc_regport.sv
module isc_regport #(
   parameter int unsigned NUM_SRC = isc_pkg::ISC_NUM_SRC,
   parameter int unsigned DATA_W  = isc_pkg::ISC_DATA_W,
   parameter int unsigned ADDR_W  = isc_pkg::ISC_ADDR_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [NUM_SRC-1:0] status_q,
   output logic [NUM_SRC-1:0] en_q,
   output logic [NUM_SRC-1:0] clr_mask,
   output logic [DATA_W-1:0]  rdata
);
   localparam int unsigned PAD_W = DATA_W - NUM_SRC;

   initial begin
      if (NUM_SRC > DATA_W) $error("isc_regport: NUM_SRC exceeds DATA_W");
      if (ADDR_W < 1)       $error("isc_regport: ADDR_W must be at least 1");
   end

   logic en_wr;
   assign en_wr = we && (addr == ADDR_W'(isc_pkg::ISC_SEL_ENABLE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= '0;
      else if (en_wr) en_q <= wdata[NUM_SRC-1:0];
   end

   // Sources written with a zero enable lose their latched bit this edge.
   assign clr_mask = en_wr ? ~wdata[NUM_SRC-1:0] : '0;

   if (PAD_W > 0) begin : g_pad
      assign rdata = {{PAD_W{1'b0}}, status_q};
   end else begin : g_nopad
      assign rdata = status_q;
   end
endmodule

// File: rtl/isc_status_bank.sv
module isc_status_bank #(
   parameter int unsigned NUM_SRC = isc_pkg::ISC_NUM_SRC
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] en_q,
   input  logic [NUM_SRC-1:0] rise,
   input  logic [NUM_SRC-1:0] clr_mask,
   output logic [NUM_SRC-1:0] status_d,
   output logic [NUM_SRC-1:0] status_q
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      // Clear has priority over a coincident set.
      always_comb begin
         if (clr_mask[i])               status_d[i] = 1'b0;
         else if (en_q[i] && rise[i])   status_d[i] = 1'b1;
         else                           status_d[i] = status_q[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) status_q[i] <= 1'b0;
         else        status_q[i] <= status_d[i];
      end
   end
endmodule

// File: rtl/isc_irq_gen.sv
module isc_irq_gen #(
   parameter int unsigned NUM_SRC = isc_pkg::ISC_NUM_SRC,
   parameter bit          REG_IRQ = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] status_d,
   input  logic [NUM_SRC-1:0] status_q,
   output logic               irq
);
   if (REG_IRQ) begin : g_reg
      logic irq_q;
      logic arm, drop;
      assign arm  = (status_q == '0) && (status_d != '0);
      assign drop = (status_d == '0);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    irq_q <= 1'b0;
         else if (arm)  irq_q <= 1'b1;
         else if (drop) irq_q <= 1'b0;
      end
      assign irq = irq_q;
   end else begin : g_comb
      assign irq = |status_q;
   end
endmodule

// File: rtl/isc_intr_ctrl.sv
module isc_intr_ctrl #(
   parameter int unsigned NUM_SRC = isc_pkg::ISC_NUM_SRC,
   parameter int unsigned DATA_W  = isc_pkg::ISC_DATA_W,
   parameter int unsigned ADDR_W  = isc_pkg::ISC_ADDR_W,
   parameter bit          REG_IRQ = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [NUM_SRC-1:0] src_in,
   output logic [NUM_SRC-1:0] status_out,
   output logic               irq_out
);
   logic [NUM_SRC-1:0] src_q;
   logic [NUM_SRC-1:0] rise;
   logic [NUM_SRC-1:0] en_q;
   logic [NUM_SRC-1:0] clr_mask;
   logic [NUM_SRC-1:0] status_d;
   logic [NUM_SRC-1:0] status_q;

   isc_edge_det #(.WIDTH(NUM_SRC)) u_edge (
      .clk(clk), .rst_n(rst_n), .sig_in(src_in), .sig_prev(src_q), .rise(rise)
   );

   isc_regport #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .status_q(status_q), .en_q(en_q), .clr_mask(clr_mask), .rdata(reg_rdata)
   );

   isc_status_bank #(.NUM_SRC(NUM_SRC)) u_stat (
      .clk(clk), .rst_n(rst_n), .en_q(en_q), .rise(rise), .clr_mask(clr_mask),
      .status_d(status_d), .status_q(status_q)
   );

   isc_irq_gen #(.NUM_SRC(NUM_SRC), .REG_IRQ(REG_IRQ)) u_irq (
      .clk(clk), .rst_n(rst_n), .status_d(status_d), .status_q(status_q), .irq(irq_out)
   );

   assign status_out = status_q;
endmodule

// File: rtl/isc_intr_ctrl_chk.sv
module isc_intr_ctrl_chk #(
   parameter int unsigned NUM_SRC = isc_pkg::ISC_NUM_SRC,
   parameter int unsigned DATA_W  = isc_pkg::ISC_DATA_W,
   parameter int unsigned ADDR_W  = isc_pkg::ISC_ADDR_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_we,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic [DATA_W-1:0]  reg_wdata,
   input logic [DATA_W-1:0]  reg_rdata,
   input logic [NUM_SRC-1:0] src_in,
   input logic [NUM_SRC-1:0] src_q,
   input logic [NUM_SRC-1:0] en_q,
   input logic [NUM_SRC-1:0] status_out,
   input logic               irq_out
);
   AST_STATUS_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (status_out & ~en_q) == '0); // R5

   AST_IRQ_TRACKS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out == (status_out != '0)); // R10

   AST_IRQ_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_out) |-> ($past(status_out) == '0)); // R9

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      AST_SET_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(status_out[i]) |-> ($past(src_in[i]) && !$past(src_q[i]) && $past(en_q[i]))); // R2

      AST_CLEAR_ONLY_BY_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(status_out[i]) |->
            $past(reg_we && (reg_addr == ADDR_W'(isc_pkg::ISC_SEL_ENABLE)) && !reg_wdata[i])); // R6
   end

   if (DATA_W > NUM_SRC) begin : g_pad
      AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         reg_rdata[DATA_W-1:NUM_SRC] == '0); // R11
   end
endmodule

bind isc_intr_ctrl isc_intr_ctrl_chk #(
   .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_in(src_in), .src_q(src_q),
   .en_q(en_q), .status_out(status_out), .irq_out(irq_out)
);

// File: tb/isc_intr_ctrl_tb.sv
`timescale 1ns/1ps
module isc_intr_ctrl_tb_top;
   localparam int unsigned NS = 6;
   localparam int unsigned DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [0:0]    reg_addr = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic [NS-1:0] src_in = '0;
   logic [NS-1:0] status_out;
   logic          irq_out;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   isc_intr_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_in(src_in),
      .status_out(status_out), .irq_out(irq_out)
   );

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req, input logic [NS-1:0] st, input logic irq);
      check(req, DW'(status_out), DW'(st));
      check(req, DW'(irq_out), DW'(irq));
      check(req, reg_rdata, DW'(st));
   endtask

   task automatic wr(input logic a, input logic [DW-1:0] d, input logic [NS-1:0] s);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d; src_in = s;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic drive_src(input logic [NS-1:0] s);
      @(negedge clk);
      src_in = s;
      @(negedge clk);
   endtask

   task automatic t_reset;
      check_all("R1 reset", 6'h00, 1'b0);
   endtask

   task automatic t_latch;
      wr(1'b0, 8'h3F, 6'h00);
      check_all("R3 enabled with no edge", 6'h00, 1'b0);
      drive_src(6'h01);
      check_all("R2 R9 R11 first edge", 6'h01, 1'b1);
      drive_src(6'h00);
      drive_src(6'h01);
      check_all("R4 sticky over re-edge", 6'h01, 1'b1);
      drive_src(6'h09);
      check_all("R2 second source", 6'h09, 1'b1);
   endtask

   task automatic t_status_write_ignored;
      wr(1'b1, 8'h00, 6'h09);
      check_all("R6 write to status address", 6'h09, 1'b1);
      drive_src(6'h0B);
      check_all("R6 enables kept", 6'h0B, 1'b1);
   endtask

   task automatic t_clear;
      wr(1'b0, 8'h37, 6'h0B);
      check_all("R5 R10 partial clear", 6'h03, 1'b1);
      wr(1'b0, 8'h34, 6'h0B);
      check_all("R10 last clear", 6'h00, 1'b0);
   endtask

   task automatic t_disabled_and_level;
      drive_src(6'h0A);
      drive_src(6'h0B);
      check_all("R3 disabled source edge", 6'h00, 1'b0);
      wr(1'b0, 8'h37, 6'h0B);
      check_all("R7 already high on enable", 6'h00, 1'b0);
      drive_src(6'h0A);
      drive_src(6'h0B);
      check_all("R7 later edge sets", 6'h01, 1'b1);
   endtask

   task automatic t_clear_wins;
      wr(1'b0, 8'h33, 6'h0F);
      check_all("R8 clear beats edge", 6'h01, 1'b1);
   endtask

   task automatic t_rearm;
      wr(1'b0, 8'h00, 6'h00);
      check_all("R10 all disabled", 6'h00, 1'b0);
      wr(1'b1, 8'hFF, 6'h00);
      check_all("R11 read at status address", 6'h00, 1'b0);
      wr(1'b0, 8'hE0, 6'h00);
      drive_src(6'h20);
      check_all("R9 R11 new interrupt", 6'h20, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_latch();
      t_status_write_ignored();
      t_clear();
      t_disabled_and_level();
      t_clear_wins();
      t_rearm();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule